// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog with two countdown stages in series, sitting behind a small register bus. The first stage counts down from its own preload value. When it runs out it can raise an interrupt, and it hands over to the second stage. The second stage counts from a separate preload value. When it runs out it records a sticky timeout flag and, if allowed, asserts a reboot request. Software keeps the system alive by reloading both stages before the first one expires.

The preload registers and the reload/flag register are guarded. Each guarded write must be preceded by its own two-write key sequence on the reload register: low byte 0x80, then low byte 0x86. A separate configuration port holds the enable, lock and function bits, plus the reboot-enable, tick-rate and interrupt-type bits. Once the lock bit is set, the watchdog cannot be switched off until reset.

A free-running clock is divided by a prescaler to produce the counting ticks. The current 20-bit count is brought out continuously.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset both preloads and `count_o` read 0xFFFFF, `irq_o`, `reboot_o` and `ctl_o` are 0, and the timeout flag (bit 9 of offset 0x0C) reads 0.
- R2: A bus write whose low byte is 0x80 to offset 0x0C, followed by one whose low byte is 0x86 to offset 0x0C, opens exactly one guarded write (offsets 0x00, 0x04, 0x0C). After that write the guard closes again.
- R3: A write to offset 0x00 or 0x04 without an open guard leaves the register unchanged. Any bus write between the 0x80 and the 0x86, other than a repeated 0x80 to 0x0C, cancels the sequence.
- R4: A read with `bus_rd` returns data on `bus_rdata` after the next clock edge. Offset 0x00 holds the stage-1 preload in bits 19:0, 0x04 the stage-2 preload, 0x08 the interrupt status in bit 0, and 0x0C the timeout flag in bit 9.
- R5: While enable (`ctl_o[1]`) is 0, the count holds the stage-1 preload, nothing expires, and `reboot_o` is 0.
- R6: A tick occurs every 2^15 clocks when mode bit 2 is 0, and every 2^5 clocks when it is 1. The tick phase restarts on enable and on reload. Each tick decrements the count by one.
- R7: A tick that finds stage 1 at zero moves to stage 2, loads the stage-2 preload, and sets the interrupt status that drives `irq_o`. So `irq_o` rises (P1+1) ticks after enable or reload.
- R8: A tick that finds stage 2 at zero sets the timeout flag. It also raises `reboot_o` if mode bit 5 is 1 and `ctl_o[2]` is 0. The count then rests at zero until a reload.
- R9: Writing bit 8 of offset 0x0C through an open guard restarts stage 1 from its preload and drops `reboot_o`.
- R10: Writing bit 9 of offset 0x0C through an open guard clears the timeout flag. Without the guard open, the write has no effect.
- R11: Writing a one to bit 0 of offset 0x08 clears the interrupt status and `irq_o`. No key sequence is needed.
- R12: `ctl_wdata` bit 0 sets the lock. While locked, the lock, enable and function bits cannot be cleared until reset.
- R13: Interrupt type 2'b11 (mode bits 1:0) suppresses the stage-1 interrupt, but the handover to stage 2 still happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 3 | bit0 lock, bit1 enable, bit2 function (1 = no reboot) |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | bit5 reboot enable, bit2 fast tick, bits1:0 interrupt type |
| ctl_o | output | 3 | Current lock, enable and function bits |
| irq_o | output | 1 | Stage-1 interrupt, held until cleared |
| reboot_o | output | 1 | Reboot request from stage-2 expiry |
| count_o | output | 20 | Current count of the active stage |

## Verification
The bench targets the key sequence:
- A guarded write with no key must be ignored. A design that ignored the guard would change the preload.
- A second write after a single key must be ignored. A design that kept the guard open would accept it.
- A stray write between the two key bytes must cancel the sequence. A design that did not reset the sequence would let a later write through.

Expiry timing is checked on the exact clock edge at both tick rates. An off-by-one in the prescaler or the zero test shows up as an interrupt or reboot one tick early or late. The bench also checks that:
- the interrupt type 2'b11 still hands over to stage 2;
- a flag clear without the key leaves the flag set;
- a locked enable survives an attempted disable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_t;
  typedef enum logic [1:0] {ST_ONE, ST_TWO, ST_DONE} stage_t;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  localparam logic [1:0] SEL_PRE1   = 2'd0;
  localparam logic [1:0] SEL_PRE2   = 2'd1;
  localparam logic [1:0] SEL_STAT   = 2'd2;
  localparam logic [1:0] SEL_RELOAD = 2'd3;

  localparam int BIT_RELOAD = 8;
  localparam int BIT_FLAG   = 9;

  localparam int CTL_LOCK = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_FUNC = 2;

  localparam int MODE_FAST   = 2;
  localparam int MODE_REBOOT = 5;
  localparam logic [1:0] IRQ_NONE = 2'b11;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       is_reload,
  input  logic       is_guarded,
  input  logic [7:0] key,
  output logic       grant,
  output logic       open_o
);
  unlock_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      UL_IDLE: if (wr && is_reload && key == KEY_FIRST) state_d = UL_HALF;
      UL_HALF: if (wr) begin
        if (is_reload && key == KEY_SECOND)     state_d = UL_OPEN;
        else if (is_reload && key == KEY_FIRST) state_d = UL_HALF;
        else                                    state_d = UL_IDLE;
      end
      UL_OPEN: if (wr && is_guarded) state_d = UL_IDLE;
      default: state_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= UL_IDLE;
    else     state_q <= state_d;
  end

  assign open_o = (state_q == UL_OPEN);
  assign grant  = open_o && wr && is_guarded;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int SLOW_LOG = 15,
  parameter int FAST_LOG = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic fast,
  output logic tick
);
  localparam logic [SLOW_LOG-1:0] SLOW_LIM = '1;
  localparam logic [SLOW_LOG-1:0] FAST_LIM = SLOW_LOG'((1 << FAST_LOG) - 1);

  logic [SLOW_LOG-1:0] div_q;
  logic [SLOW_LOG-1:0] lim;

  assign lim  = fast ? FAST_LIM : SLOW_LIM;
  assign tick = run && (div_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) div_q <= '0;
    else                                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdog_stages.sv
module wdog_stages
  import wdog_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             reload,
  input  logic             irq_mute,
  input  logic             reboot_ok,
  input  logic             irq_clr,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             flag_o,
  output logic             reboot_o,
  output logic             in_two
);
  stage_t            stage_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              at_zero, step, end_one, end_two;

  assign at_zero = (cnt_q == '0);
  assign step    = en && !reload && tick;
  assign end_one = step && at_zero && stage_q == ST_ONE;
  assign end_two = step && at_zero && stage_q == ST_TWO;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '1;
      stage_q  <= ST_ONE;
      reboot_o <= 1'b0;
    end else if (!en || reload) begin
      cnt_q    <= pre1;
      stage_q  <= ST_ONE;
      reboot_o <= 1'b0;
    end else if (end_one) begin
      cnt_q   <= pre2;
      stage_q <= ST_TWO;
    end else if (end_two) begin
      stage_q  <= ST_DONE;
      reboot_o <= reboot_ok;
    end else if (step && !at_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (end_one && !irq_mute) irq_o <= 1'b1;
      else if (irq_clr)         irq_o <= 1'b0;
      if (end_two)              flag_o <= 1'b1;
      else if (flag_clr)        flag_o <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign in_two  = (stage_q == ST_TWO);
endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int DATA_W   = 32,
  parameter int SLOW_LOG = 15,
  parameter int FAST_LOG = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  output logic [2:0]        ctl_o,
  output logic              irq_o,
  output logic              reboot_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [1:0]       sel;
  logic             is_reload, is_guarded, grant, unl_open;
  logic             reload_req, flag_clr, irq_clr, tick, sticky, in_two;
  logic [CNT_W-1:0] pre1_q, pre2_q;
  logic [7:0]       mode_q;
  logic [2:0]       ctl_q;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_bits;

  assign sel        = bus_addr[3:2];
  assign is_reload  = (sel == SEL_RELOAD);
  assign is_guarded = (sel != SEL_STAT);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CNT_W], mode_q[7:6], mode_q[4:3]};

  wdog_unlock u_unlock (
    .clk(clk), .rst(rst), .wr(bus_wr), .is_reload(is_reload),
    .is_guarded(is_guarded), .key(bus_wdata[7:0]),
    .grant(grant), .open_o(unl_open)
  );

  assign reload_req = grant && is_reload && bus_wdata[BIT_RELOAD];
  assign flag_clr   = grant && is_reload && bus_wdata[BIT_FLAG];
  assign irq_clr    = bus_wr && (sel == SEL_STAT) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre1_q <= '1;
      pre2_q <= '1;
      mode_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (grant && sel == SEL_PRE1) pre1_q <= bus_wdata[CNT_W-1:0];
      if (grant && sel == SEL_PRE2) pre2_q <= bus_wdata[CNT_W-1:0];
      if (mode_wr) mode_q <= mode_wdata;
      if (ctl_wr) begin
        if (ctl_q[CTL_LOCK]) ctl_q <= ctl_q | ctl_wdata;
        else                 ctl_q <= ctl_wdata;
      end
    end
  end

  wdog_prescale #(.SLOW_LOG(SLOW_LOG), .FAST_LOG(FAST_LOG)) u_prescale (
    .clk(clk), .rst(rst), .run(ctl_q[CTL_EN]), .restart(reload_req),
    .fast(mode_q[MODE_FAST]), .tick(tick)
  );

  wdog_stages #(.CNT_W(CNT_W)) u_stages (
    .clk(clk), .rst(rst), .en(ctl_q[CTL_EN]), .tick(tick), .reload(reload_req),
    .irq_mute(mode_q[1:0] == IRQ_NONE),
    .reboot_ok(mode_q[MODE_REBOOT] && !ctl_q[CTL_FUNC]),
    .irq_clr(irq_clr), .flag_clr(flag_clr), .pre1(pre1_q), .pre2(pre2_q),
    .count_o(count_o), .irq_o(irq_o), .flag_o(sticky), .reboot_o(reboot_o),
    .in_two(in_two)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_PRE1: rd_mux = {{PAD_W{1'b0}}, pre1_q};
      SEL_PRE2: rd_mux = {{PAD_W{1'b0}}, pre2_q};
      SEL_STAT: rd_mux[0] = irq_o;
      default:  rd_mux[BIT_FLAG] = sticky;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       reboot,
  input logic [2:0] ctl,
  input logic       flag,
  input logic       in_two,
  input logic       grant,
  input logic       unl_open,
  input logic       reload_req
);
  a_r2_single_use: assert property (@(posedge clk) disable iff (rst)
    grant |=> !unl_open);
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !ctl[1] |=> !reboot);
  a_r7_irq_at_handover: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> in_two);
  a_r8_flag_with_reboot: assert property (@(posedge clk) disable iff (rst)
    $rose(reboot) |-> flag);
  a_r9_reload_drops_reboot: assert property (@(posedge clk) disable iff (rst)
    reload_req |=> !reboot);
  a_r12_lock_holds: assert property (@(posedge clk) disable iff (rst)
    ctl[0] |=> ctl[0]);
  a_r12_enable_holds: assert property (@(posedge clk) disable iff (rst)
    (ctl[0] && ctl[1]) |=> ctl[1]);
endmodule

bind dual_stage_wdog wdog_checker u_chk (
  .clk(clk), .rst(rst), .irq(irq_o), .reboot(reboot_o), .ctl(ctl_o),
  .flag(sticky), .in_two(in_two), .grant(grant), .unl_open(unl_open),
  .reload_req(reload_req)
);

// File: tb/dual_stage_wdog_bench.sv
module dual_stage_wdog_bench;
  localparam int DF = 32;
  localparam int DS = 32768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, ctl_wr = 1'b0, mode_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  ctl_wdata = '0;
  logic [7:0]  mode_wdata = '0;
  logic [2:0]  ctl_o;
  logic        irq_o, reboot_o;
  logic [19:0] count_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dual_stage_wdog u_dual_stage_wdog (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ctl_o(ctl_o), .irq_o(irq_o), .reboot_o(reboot_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int irq_edges(input int p1, input int d);
    return d * (p1 + 1);
  endfunction

  function automatic int boot_edges(input int p1, input int p2, input int d);
    return d * (p1 + p2 + 2);
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic unlock();
    bw(4'hC, 32'h80); bw(4'hC, 32'h86);
  endtask

  task automatic reload();
    unlock(); bw(4'hC, 32'h100);
  endtask

  task automatic ctl(input logic [2:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic mode(input logic [7:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; waitn(3); rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    chk("R1 count", count_o, 32'hFFFFF);
    chk("R1 irq", irq_o, 0);
    chk("R1 reboot", reboot_o, 0);
    chk("R1 ctl", ctl_o, 0);
    br(4'hC, rd); chk("R1 flag", rd, 0);
    br(4'h0, rd); chk("R4 pre1 reset", rd, 32'hFFFFF);
    // R3 guarded write without key
    bw(4'h0, 32'd20); br(4'h0, rd); chk("R3 no key", rd, 32'hFFFFF);
    // R2 one write per key
    unlock(); bw(4'h0, 32'd10); br(4'h0, rd); chk("R2 keyed write", rd, 10);
    bw(4'h0, 32'd7); br(4'h0, rd); chk("R2 relocked", rd, 10);
    unlock(); bw(4'h4, 32'd3); br(4'h4, rd); chk("R4 pre2", rd, 3);
    // R3 aborted sequences
    bw(4'hC, 32'h80); bw(4'hC, 32'h55); bw(4'hC, 32'h86); bw(4'h0, 32'd99);
    br(4'h0, rd); chk("R3 abort by value", rd, 10);
    bw(4'hC, 32'h80); bw(4'h8, 32'h0); bw(4'hC, 32'h86); bw(4'h0, 32'd99);
    br(4'h0, rd); chk("R3 abort by offset", rd, 10);
    // R5 disabled holds preload
    waitn(100);
    chk("R5 hold count", count_o, 10);
    chk("R5 no irq", irq_o, 0);
    // R6/R7/R8 fast tick, reboot disabled
    mode(8'h04); ctl(3'b010);
    waitn(DF - 1); chk("R6 before tick", count_o, 10);
    waitn(1);      chk("R6 first tick", count_o, 9);
    waitn(irq_edges(10, DF) - DF - 1); chk("R7 irq early", irq_o, 0);
    waitn(1); chk("R7 irq rise", irq_o, 1); chk("R7 pre2 load", count_o, 3);
    waitn(boot_edges(10, 3, DF) - irq_edges(10, DF)); chk("R8 no reboot when off", reboot_o, 0);
    br(4'hC, rd); chk("R8 flag set", rd, 32'h200);
    // R11 clear irq without key
    bw(4'h8, 32'h1); chk("R11 irq cleared", irq_o, 0);
    // R10 flag clear needs key
    bw(4'hC, 32'h200); br(4'hC, rd); chk("R10 no key keeps flag", rd, 32'h200);
    unlock(); bw(4'hC, 32'h200); br(4'hC, rd); chk("R10 flag cleared", rd, 0);
    // R8/R9 reboot path
    mode(8'h24); reload();
    chk("R9 reload count", count_o, 10);
    waitn(boot_edges(10, 3, DF) - 1); chk("R8 reboot early", reboot_o, 0);
    waitn(1); chk("R8 reboot rise", reboot_o, 1);
    reload(); chk("R9 reboot dropped", reboot_o, 0);
    bw(4'h8, 32'h1);
    for (int k = 0; k < 5; k++) begin waitn(200); reload(); end
    chk("R9 keepalive irq", irq_o, 0);
    chk("R9 keepalive reboot", reboot_o, 0);
    // R13 muted interrupt still hands over
    mode(8'h27); reload();
    waitn(irq_edges(10, DF));
    chk("R13 no irq", irq_o, 0);
    chk("R13 handover", count_o, 3);
    // R6 slow tick
    mode(8'h20); reload();
    waitn(DS - 1); chk("R6 slow before", count_o, 10);
    waitn(1);      chk("R6 slow tick", count_o, 9);
    // R7 random preloads
    for (int i = 0; i < 6; i++) begin
      int p1, p2;
      p1 = $urandom_range(1, 12); p2 = $urandom_range(1, 12);
      ctl(3'b000);
      unlock(); bw(4'h0, p1); unlock(); bw(4'h4, p2);
      mode(8'h04); bw(4'h8, 32'h1);
      chk("R5 tracks preload", count_o, p1);
      ctl(3'b010);
      waitn(irq_edges(p1, DF) - 1); chk("R7 rand early", irq_o, 0);
      waitn(1); chk("R7 rand irq", irq_o, 1); chk("R7 rand pre2", count_o, p2);
    end
    // R12 lock
    ctl(3'b011); ctl(3'b000);
    chk("R12 locked ctl", ctl_o, 3'b011);
    do_reset();
    chk("R1 lock cleared by reset", ctl_o, 0);
    finish_run();
  end
endmodule